// File: doc/BRIEF.md
# Clos Middle-Stage Per-Flow Crosspoint Switch

This block is the middle stage of a three-stage buffered Clos cell switch. It has `NUM_LINKS` ingress links, one from each input-stage module, and the same number of egress links, one to each output-stage module. Each output-stage module serves `MOD_PORTS` ports. In every time slot (one clock cycle) each ingress link can present one fixed-length cell. The cell carries the index of its destination module and of the destination port within that module. The cell is stored in a dedicated queue for its (ingress link, destination module, destination port) triple, so the block holds `NUM_LINKS * NUM_LINKS * MOD_PORTS` queues of `Q_DEPTH` cells each.

Each egress link has a round-robin arbiter that picks one queue per slot. Only queues that hold a cell and whose destination port still has downstream credit take part. A cell waiting for a congested port therefore never holds back cells bound for other ports of the same module. Flow control uses credits in both directions. Per destination port, a counter tracks the free space in the downstream per-port queue, and credits flow back into it from the output-stage module. Each cell that leaves returns a one-cycle credit pulse toward its input-stage module, so the upstream side can track free space in every queue.

Top module: `clos_cm_switch`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `out_valid` and `up_credit` are all zero. After reset every queue is empty and every port credit counter equals `DS_DEPTH`.
- R2: A cell on ingress link i with `in_mod` = j and `in_port` = h is stored only in queue (i, j, h). It later appears on egress link j with `out_port` = h, `out_src` = i and unchanged data, and it is neither lost nor duplicated.
- R3: A cell is never pushed into a full queue when the upstream side respects its credits. Each departure from queue (i, j, h) raises `up_credit[(i*NUM_LINKS + j)*MOD_PORTS + h]` for exactly one cycle, in the same cycle as the matching `out_valid`.
- R4: Cells of one flow leave in the order in which they arrived.
- R5: A cell accepted at a clock edge can appear at an egress no earlier than the output of the next edge. Egress outputs are registered, so a grant made at an edge is visible after that edge.
- R6: For each port (j, h), at most `DS_DEPTH` cells are outstanding downstream. A port whose credit is zero is skipped, while cells for the other ports of the same module continue to flow. `ds_credit[j*MOD_PORTS + h]` adds one credit. A send and a returned credit in the same cycle cancel.
- R7: Egress j ranks candidate queues by c = i*MOD_PORTS + h. It grants the first eligible c at or after its pointer, in circular order, and then moves the pointer to c+1 modulo `NUM_LINKS*MOD_PORTS`. At most one queue per egress is popped per cycle.
- R8: When an egress has no eligible queue, its `out_valid` is low in the next cycle and its pointer does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one time slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | NUM_LINKS | Cell present on ingress link i |
| in_mod | input | NUM_LINKS*MW | Destination module per ingress link |
| in_port | input | NUM_LINKS*PW | Destination port within the module per ingress link |
| in_data | input | NUM_LINKS*CELL_W | Cell payload per ingress link |
| up_credit | output | NUM_LINKS*NUM_LINKS*MOD_PORTS | One-cycle credit pulse per queue toward its input-stage module |
| out_valid | output | NUM_LINKS | Cell present on egress link j |
| out_port | output | NUM_LINKS*PW | Destination port of the egress cell |
| out_src | output | NUM_LINKS*MW | Ingress link the egress cell came from |
| out_data | output | NUM_LINKS*CELL_W | Egress cell payload |
| ds_credit | input | NUM_LINKS*MOD_PORTS | Returned credit per destination port (j, h) |

## Verification
The assertions check several properties on every cycle:
- no cell is pushed into a full queue;
- the downstream occupancy of each port, tracked by a counter in the checker, stays within its credit window;
- the number of upstream credit pulses matches the number of egress cells;
- each egress pops at most one queue;
- an egress with nothing stored goes idle.

Other behaviours can only be shown by the bench's scenarios, which drive traffic against a cycle-by-cycle reference model:
- the round-robin rotation and pointer hold;
- correct routing;
- in-flow ordering;
- absence of loss;
- cells for a free port still passing while another port of the same module is held without credit.

// File: rtl/clos_cm_pkg.sv
package clos_cm_pkg;
    // Width needed to hold indexes 0..v-1, at least one bit.
    function automatic int unsigned bits_for(input int unsigned v);
        return (v > 1) ? $clog2(v) : 1;
    endfunction
endpackage

// File: rtl/flow_fifo.sv
module flow_fifo
    import clos_cm_pkg::*;
#(
    parameter int unsigned DEPTH = 2,
    parameter int unsigned W     = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int unsigned AW   = bits_for(DEPTH);
    localparam int unsigned CNTW = bits_for(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0]   rd;
        logic [AW-1:0]   wr;
        logic [CNTW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (st_q.cnt == '0);
    assign full    = (st_q.cnt == CNTW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem_q[st_q.rd];

    always_comb begin
        st_d = st_q;
        if (do_push) st_d.wr = bump(st_q.wr);
        if (do_pop)  st_d.rd = bump(st_q.rd);
        if (do_push && !do_pop)      st_d.cnt = st_q.cnt + 1'b1;
        else if (do_pop && !do_push) st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wr] <= din;
    end
endmodule

// File: rtl/egress_arb.sv
module egress_arb
    import clos_cm_pkg::*;
#(
    parameter int unsigned NUM_LINKS = 2,
    parameter int unsigned MOD_PORTS = 2,
    parameter int unsigned CELL_W    = 16,
    parameter int unsigned DS_DEPTH  = 2,
    localparam int unsigned NC  = NUM_LINKS * MOD_PORTS,
    localparam int unsigned MW  = bits_for(NUM_LINKS),
    localparam int unsigned PW  = bits_for(MOD_PORTS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NC-1:0]              cand_ready,
    input  logic [NC-1:0][CELL_W-1:0]  cand_head,
    input  logic [MOD_PORTS-1:0]       ds_credit,
    output logic [NC-1:0]              grant,
    output logic                       out_valid,
    output logic [PW-1:0]              out_port,
    output logic [MW-1:0]              out_src,
    output logic [CELL_W-1:0]          out_data
);
    localparam int unsigned CW  = bits_for(NC);
    localparam int unsigned CRW = bits_for(DS_DEPTH + 1);

    typedef struct packed {
        logic [CW-1:0]                   ptr;
        logic [MOD_PORTS-1:0][CRW-1:0]   cred;
        logic                            vld;
        logic [PW-1:0]                   port;
        logic [MW-1:0]                   src;
        logic [CELL_W-1:0]               data;
    } arb_st_t;

    arb_st_t st_d, st_q;

    always_comb begin
        logic [NC-1:0] elig;
        logic          found;
        int unsigned   pick;
        int unsigned   idx;
        st_d     = st_q;
        st_d.vld = 1'b0;
        grant    = '0;
        found    = 1'b0;
        pick     = 0;
        // Eligible: queue holds a cell and its destination port has credit.
        for (int unsigned c = 0; c < NC; c++) begin
            elig[c] = cand_ready[c] && (st_q.cred[c % MOD_PORTS] != '0);
        end
        // Circular search starting at the pointer.
        for (int unsigned k = 0; k < NC; k++) begin
            idx = (int'(st_q.ptr) + k) % NC;
            if (!found && elig[idx]) begin
                found = 1'b1;
                pick  = idx;
            end
        end
        if (found) begin
            grant[pick] = 1'b1;
            st_d.vld    = 1'b1;
            st_d.port   = PW'(pick % MOD_PORTS);
            st_d.src    = MW'(pick / MOD_PORTS);
            st_d.data   = cand_head[pick];
            st_d.ptr    = CW'((pick + 1) % NC);
        end
        for (int unsigned h = 0; h < MOD_PORTS; h++) begin
            st_d.cred[h] = st_q.cred[h] + CRW'(ds_credit[h])
                         - CRW'(found && ((pick % MOD_PORTS) == h));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int unsigned h = 0; h < MOD_PORTS; h++) begin
                st_q.cred[h] <= CRW'(DS_DEPTH);
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_port  = st_q.port;
    assign out_src   = st_q.src;
    assign out_data  = st_q.data;
endmodule

// File: rtl/clos_cm_switch.sv
module clos_cm_switch
    import clos_cm_pkg::*;
#(
    parameter int unsigned NUM_LINKS = 2,
    parameter int unsigned MOD_PORTS = 2,
    parameter int unsigned CELL_W    = 16,
    parameter int unsigned Q_DEPTH   = 2,
    parameter int unsigned DS_DEPTH  = 2,
    localparam int unsigned MW = bits_for(NUM_LINKS),
    localparam int unsigned PW = bits_for(MOD_PORTS),
    localparam int unsigned NQ = NUM_LINKS * NUM_LINKS * MOD_PORTS,
    localparam int unsigned NC = NUM_LINKS * MOD_PORTS
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_LINKS-1:0]          in_valid,
    input  logic [NUM_LINKS*MW-1:0]       in_mod,
    input  logic [NUM_LINKS*PW-1:0]       in_port,
    input  logic [NUM_LINKS*CELL_W-1:0]   in_data,
    output logic [NQ-1:0]                 up_credit,
    output logic [NUM_LINKS-1:0]          out_valid,
    output logic [NUM_LINKS*PW-1:0]       out_port,
    output logic [NUM_LINKS*MW-1:0]       out_src,
    output logic [NUM_LINKS*CELL_W-1:0]   out_data,
    input  logic [NC-1:0]                 ds_credit
);
    logic [NQ-1:0]     q_push, q_pop, q_empty, q_full;
    logic [CELL_W-1:0] q_head [NQ];
    logic [NQ-1:0]     upc_d, upc_q;

    // Per-flow queues, indexed (i*NUM_LINKS + j)*MOD_PORTS + h.
    for (genvar i = 0; i < NUM_LINKS; i++) begin : g_in
        for (genvar j = 0; j < NUM_LINKS; j++) begin : g_mod
            for (genvar h = 0; h < MOD_PORTS; h++) begin : g_port
                localparam int unsigned Q = (i * NUM_LINKS + j) * MOD_PORTS + h;
                assign q_push[Q] = in_valid[i]
                                && (in_mod[i*MW +: MW] == MW'(j))
                                && (in_port[i*PW +: PW] == PW'(h));
                flow_fifo #(.DEPTH(Q_DEPTH), .W(CELL_W)) u_q (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .push  (q_push[Q]),
                    .din   (in_data[i*CELL_W +: CELL_W]),
                    .pop   (q_pop[Q]),
                    .dout  (q_head[Q]),
                    .empty (q_empty[Q]),
                    .full  (q_full[Q])
                );
            end
        end
    end

    // One arbiter per egress link; candidate c = i*MOD_PORTS + h.
    for (genvar j = 0; j < NUM_LINKS; j++) begin : g_eg
        logic [NC-1:0]             rdy, gnt;
        logic [NC-1:0][CELL_W-1:0] head;
        for (genvar i = 0; i < NUM_LINKS; i++) begin : g_ci
            for (genvar h = 0; h < MOD_PORTS; h++) begin : g_ch
                localparam int unsigned Q = (i * NUM_LINKS + j) * MOD_PORTS + h;
                localparam int unsigned C = i * MOD_PORTS + h;
                assign rdy[C]   = !q_empty[Q];
                assign head[C]  = q_head[Q];
                assign q_pop[Q] = gnt[C];
            end
        end
        egress_arb #(
            .NUM_LINKS (NUM_LINKS),
            .MOD_PORTS (MOD_PORTS),
            .CELL_W    (CELL_W),
            .DS_DEPTH  (DS_DEPTH)
        ) u_arb (
            .clk        (clk),
            .rst_n      (rst_n),
            .cand_ready (rdy),
            .cand_head  (head),
            .ds_credit  (ds_credit[j*MOD_PORTS +: MOD_PORTS]),
            .grant      (gnt),
            .out_valid  (out_valid[j]),
            .out_port   (out_port[j*PW +: PW]),
            .out_src    (out_src[j*MW +: MW]),
            .out_data   (out_data[j*CELL_W +: CELL_W])
        );
    end

    // Upstream credit pulses, registered to line up with the egress cell.
    always_comb begin
        upc_d = q_pop;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) upc_q <= '0;
        else        upc_q <= upc_d;
    end

    assign up_credit = upc_q;
endmodule

// File: rtl/clos_cm_checker.sv
module clos_cm_checker
    import clos_cm_pkg::*;
#(
    parameter int unsigned NUM_LINKS = 2,
    parameter int unsigned MOD_PORTS = 2,
    parameter int unsigned DS_DEPTH  = 2,
    localparam int unsigned PW = bits_for(MOD_PORTS),
    localparam int unsigned NQ = NUM_LINKS * NUM_LINKS * MOD_PORTS,
    localparam int unsigned NC = NUM_LINKS * MOD_PORTS
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NQ-1:0]            q_push,
    input logic [NQ-1:0]            q_full,
    input logic [NQ-1:0]            q_pop,
    input logic [NQ-1:0]            q_empty,
    input logic [NUM_LINKS-1:0]     out_valid,
    input logic [NUM_LINKS*PW-1:0]  out_port,
    input logic [NQ-1:0]            up_credit,
    input logic [NC-1:0]            ds_credit
);
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q_push & q_full) == '0);

    assert_credit_return_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(up_credit) == $countones(out_valid));

    assert_idle_egress_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (&q_empty) |=> (out_valid == '0));

    for (genvar x = 0; x < NC; x++) begin : g_ds
        localparam int unsigned J = x / MOD_PORTS;
        localparam int unsigned H = x % MOD_PORTS;
        int  outst;
        logic hit;
        assign hit = out_valid[J] && (out_port[J*PW +: PW] == PW'(H));
        always_ff @(posedge clk) begin
            if (!rst_n) outst <= 0;
            else        outst <= outst + (hit ? 1 : 0) - (ds_credit[x] ? 1 : 0);
        end
        assert_ds_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
            outst <= int'(DS_DEPTH));
    end

    for (genvar j = 0; j < NUM_LINKS; j++) begin : g_pj
        logic [NC-1:0] pops;
        for (genvar c = 0; c < NC; c++) begin : g_c
            assign pops[c] = q_pop[((c / MOD_PORTS) * NUM_LINKS + j) * MOD_PORTS + (c % MOD_PORTS)];
        end
        assert_single_pick_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(pops));
    end
endmodule

bind clos_cm_switch clos_cm_checker #(
    .NUM_LINKS (NUM_LINKS),
    .MOD_PORTS (MOD_PORTS),
    .DS_DEPTH  (DS_DEPTH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .q_push    (q_push),
    .q_full    (q_full),
    .q_pop     (q_pop),
    .q_empty   (q_empty),
    .out_valid (out_valid),
    .out_port  (out_port),
    .up_credit (up_credit),
    .ds_credit (ds_credit)
);

// File: tb/sim_clos_cm_switch.sv
module sim_clos_cm_switch;
    localparam int P  = 2;
    localparam int N  = 2;
    localparam int W  = 16;
    localparam int QD = 2;
    localparam int DD = 2;
    localparam int MW = 1;
    localparam int PW = 1;
    localparam int NQ = P * P * N;
    localparam int NC = P * N;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [P-1:0]    in_valid = '0;
    logic [P*MW-1:0] in_mod = '0;
    logic [P*PW-1:0] in_port = '0;
    logic [P*W-1:0]  in_data = '0;
    logic [NQ-1:0]   up_credit;
    logic [P-1:0]    out_valid;
    logic [P*PW-1:0] out_port;
    logic [P*MW-1:0] out_src;
    logic [P*W-1:0]  out_data;
    logic [NC-1:0]   ds_credit = '0;

    always #2 clk = ~clk;

    clos_cm_switch #(.NUM_LINKS(P), .MOD_PORTS(N), .CELL_W(W),
                     .Q_DEPTH(QD), .DS_DEPTH(DD)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mod(in_mod),
        .in_port(in_port), .in_data(in_data), .up_credit(up_credit),
        .out_valid(out_valid), .out_port(out_port), .out_src(out_src),
        .out_data(out_data), .ds_credit(ds_credit));

    int checks = 0;
    int fails  = 0;

    // Reference model state
    logic [W-1:0] mq   [NQ][$];
    logic [W-1:0] sent [NQ][$];
    int mcred [NC];
    int mptr  [P];
    int ucred [NQ];
    int docc  [NC];
    bit stall [NC];
    bit       exp_vld  [P];
    int       exp_port [P];
    int       exp_src  [P];
    logic [W-1:0] exp_data [P];
    logic [NQ-1:0] exp_upc;
    int serial = 1;
    int mode = 0;        // 0 idle, 1 uniform, 2 module 0 only
    int free_port_hits = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic step();
        logic [P-1:0]  nv;
        logic [NC-1:0] nds;
        int dj [P];
        int dh [P];
        @(negedge clk);
        // Compare outputs registered at the last edge.
        for (int j = 0; j < P; j++) begin
            chk(out_valid[j] == exp_vld[j], "R7", "egress valid", out_valid[j], exp_vld[j]);
            if (exp_vld[j] && out_valid[j]) begin
                chk(int'(out_port[j*PW +: PW]) == exp_port[j], "R2", "egress port",
                    out_port[j*PW +: PW], exp_port[j]);
                chk(int'(out_src[j*MW +: MW]) == exp_src[j], "R7", "egress source",
                    out_src[j*MW +: MW], exp_src[j]);
                chk(out_data[j*W +: W] == exp_data[j], "R2", "egress data",
                    out_data[j*W +: W], exp_data[j]);
            end
            if (out_valid[j]) begin
                int q;
                int x;
                q = (int'(out_src[j*MW +: MW]) * P + j) * N + int'(out_port[j*PW +: PW]);
                x = j * N + int'(out_port[j*PW +: PW]);
                if (sent[q].size() == 0) begin
                    chk(1'b0, "R2", "cell with no matching send", out_data[j*W +: W], 0);
                end else begin
                    chk(out_data[j*W +: W] == sent[q][0], "R4", "flow order",
                        out_data[j*W +: W], sent[q][0]);
                    void'(sent[q].pop_front());
                end
                docc[x]++;
                chk(docc[x] <= DD, "R6", "downstream occupancy", docc[x], DD);
                if (mode == 2 && x == 1) free_port_hits++;
            end
        end
        chk(up_credit == exp_upc, "R3", "upstream credit pulses", up_credit, exp_upc);
        for (int q = 0; q < NQ; q++) if (up_credit[q]) ucred[q]++;

        // Choose new ingress cells, respecting upstream credits.
        nv = '0;
        for (int i = 0; i < P; i++) begin
            int q;
            dj[i] = (mode == 2) ? 0 : int'($urandom % P);
            dh[i] = int'($urandom % N);
            q = (i * P + dj[i]) * N + dh[i];
            if (mode != 0 && ($urandom % 4) != 0 && ucred[q] > 0) begin
                nv[i] = 1'b1;
                ucred[q]--;
                in_mod[i*MW +: MW]  = MW'(dj[i]);
                in_port[i*PW +: PW] = PW'(dh[i]);
                in_data[i*W +: W]   = W'(serial);
                sent[q].push_back(W'(serial));
                serial++;
            end
        end
        in_valid = nv;
        // Return downstream credits.
        nds = '0;
        for (int x = 0; x < NC; x++) begin
            if (!stall[x] && docc[x] > 0 && ($urandom % 2) == 0) begin
                nds[x] = 1'b1;
                docc[x]--;
            end
        end
        ds_credit = nds;

        // Model the coming edge: pick on pre-edge state, then update.
        exp_upc = '0;
        for (int j = 0; j < P; j++) begin
            bit found;
            found = 1'b0;
            exp_vld[j] = 1'b0;
            for (int k = 0; k < NC; k++) begin
                int c;
                int q;
                c = (mptr[j] + k) % NC;
                q = ((c / N) * P + j) * N + (c % N);
                if (!found && mq[q].size() > 0 && mcred[j * N + c % N] > 0) begin
                    found = 1'b1;
                    exp_vld[j]  = 1'b1;
                    exp_port[j] = c % N;
                    exp_src[j]  = c / N;
                    exp_data[j] = mq[q].pop_front();
                    exp_upc[q]  = 1'b1;
                    mcred[j * N + c % N]--;
                    mptr[j] = (c + 1) % NC;
                end
            end
        end
        for (int x = 0; x < NC; x++) if (nds[x]) mcred[x]++;
        for (int i = 0; i < P; i++) begin
            if (nv[i]) mq[(i * P + dj[i]) * N + dh[i]].push_back(in_data[i*W +: W]);
        end
    endtask

    initial begin
        #(4 * 190000);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        for (int q = 0; q < NQ; q++) ucred[q] = QD;
        for (int x = 0; x < NC; x++) begin
            mcred[x] = DD;
            docc[x]  = 0;
            stall[x] = 1'b0;
        end
        for (int j = 0; j < P; j++) begin
            mptr[j] = 0;
            exp_vld[j] = 1'b0;
        end
        exp_upc = '0;
        repeat (4) @(negedge clk);
        chk(out_valid == '0, "R1", "valid in reset", out_valid, 0);
        chk(up_credit == '0, "R1", "credit pulses in reset", up_credit, 0);
        rst_n = 1'b1;

        // Uniform traffic to every port.
        mode = 1;
        repeat (600) step();

        // Port (0,0) held without credit; port (0,1) must keep flowing (R6).
        mode = 2;
        stall[0] = 1'b1;
        free_port_hits = 0;
        repeat (600) step();
        chk(free_port_hits > 20, "R6", "cells to free port while sibling stalled",
            free_port_hits, 21);

        // Release, stop traffic and drain.
        stall[0] = 1'b0;
        mode = 0;
        repeat (200) step();
        begin
            int left;
            left = 0;
            for (int q = 0; q < NQ; q++) left += sent[q].size();
            chk(left == 0, "R2", "cells not delivered after drain", left, 0);
        end
        repeat (10) step();
        chk(out_valid == '0, "R8", "idle egress after drain", out_valid, 0);
        chk(up_credit == '0, "R8", "no credit pulses when idle", up_credit, 0);
        // R5: every cell was matched one edge after the model's grant above.
        summary();
    end
endmodule